// File: doc/BRIEF.md
# Local Interrupt Vector Table Controller

This block keeps one configuration entry for each of six local interrupt sources: timer, thermal, performance counter, external pin 0, external pin 1 and error. Each entry gives its source a vector, a delivery mode, an input polarity, an edge or level trigger and a mask. The block conditions each raw source line by that configuration and latches a request. It then presents one pending request at a time, with its vector and delivery mode, to a downstream acceptance unit. That unit returns an acknowledge.

Software reaches the entries through a word-wide register port. Entry `i` sits at offset `i*0x10`. Byte strobes let one field group be rewritten without touching the others. An end-of-interrupt input carries a vector. It releases level-triggered entries that are waiting on remote acceptance.

Top module: `lvt_ctrl`

## Requirements
- R1: After reset every entry reads 0x0001_0000, so only the mask bit is set, and `req_valid_o` is 0.
- R2: Entry `i` (0..5) is reached at address `i*0x10`. Its word holds vector [7:0], delivery mode [10:8] (000 fixed, 010 SMI, 100 NMI, 111 external), delivery status [12], polarity [13] (1 = active low), remote IRR [14], trigger [15] (1 = level) and mask [16]. All other bits read 0. An address with a nonzero low nibble or an index above 5 reads 0, and writes to it change nothing.
- R3: Byte strobe 0 writes only the vector. Strobe 1 writes mode, polarity and trigger. Strobe 2 writes the mask. Bits 12 and 14 ignore writes.
- R4: A source is active when its input differs from its polarity bit.
- R5: An unmasked edge entry latches one request on an inactive-to-active change. The request is held after the input goes inactive. Further edges while it is pending add nothing.
- R6: An unmasked level entry raises a request while active, not pending and with remote IRR clear. A fixed-mode level request that is acknowledged sets remote IRR. No request is raised while remote IRR is set. An end-of-interrupt whose vector equals the entry's vector clears remote IRR, and any other vector leaves it set.
- R7: Delivery status is 1 from the edge that raises a request until the edge that acknowledges it.
- R8: A masked entry is never presented. Edges and levels seen while masked latch nothing. A request already pending when the entry is masked stays pending and is presented again after the entry is unmasked.
- R9: Among presented entries the lowest index wins. `req_vec_o` and `req_mode_o` carry that entry's fields.
- R10: A request becomes visible on the first clock edge after the input change, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 6 | Raw source lines, one per entry |
| reg_we_i | input | 1 | Register write strobe |
| reg_be_i | input | 4 | Byte strobes for the write |
| reg_addr_i | input | 7 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed entry (combinational) |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_vec_i | input | 8 | Vector being retired |
| req_valid_o | output | 1 | A request is presented |
| req_vec_o | output | 8 | Vector of the presented request |
| req_mode_o | output | 3 | Delivery mode of the presented request |
| req_ack_i | input | 1 | Acceptance of the presented request |

## Verification
The assertions assume that `req_ack_i` is raised only while `req_valid_o` is high, and that it is taken as acceptance of the entry presented in that same cycle. They also assume that an end-of-interrupt never coincides with the acknowledge of the same level entry. The bench drives acknowledge only after it has seen a valid request with the expected vector. It issues end-of-interrupt in cycles with no acknowledge pending. It changes polarity or trigger only while the entry is masked, so that reconfiguration does not create false edges.

// File: rtl/lvt_pkg.sv
package lvt_pkg;
  localparam int WORD_W = 32;
  localparam int VEC_W  = 8;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] DM_FIXED = 3'b000;
  localparam logic [MODE_W-1:0] DM_SMI   = 3'b010;
  localparam logic [MODE_W-1:0] DM_NMI   = 3'b100;
  localparam logic [MODE_W-1:0] DM_EXT   = 3'b111;

  localparam int B_STATUS = 12;
  localparam int B_POL    = 13;
  localparam int B_RIRR   = 14;
  localparam int B_TRIG   = 15;
  localparam int B_MASK   = 16;

  typedef struct packed {
    logic              mask;
    logic              trig;
    logic              pol;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } cfg_t;
endpackage

// File: rtl/lvt_entry.sv
module lvt_entry
  import lvt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_i,
  input  logic              wr_i,
  input  logic [3:0]        be_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              eoi_i,
  input  logic [VEC_W-1:0]  eoi_vec_i,
  input  logic              clr_i,
  output cfg_t              cfg_o,
  output logic              pend_o,
  output logic              rirr_o,
  output logic              req_o,
  output logic [WORD_W-1:0] word_o
);
  cfg_t cfg_q;
  logic act, act_q, pend_q, rirr_q, fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mask: 1'b1, default: '0};
    end else if (wr_i) begin
      if (be_i[0]) cfg_q.vec <= wdata_i[VEC_W-1:0];
      if (be_i[1]) begin
        cfg_q.mode <= wdata_i[10:8];
        cfg_q.pol  <= wdata_i[B_POL];
        cfg_q.trig <= wdata_i[B_TRIG];
      end
      if (be_i[2]) cfg_q.mask <= wdata_i[B_MASK];
    end
  end

  assign act  = src_i ^ cfg_q.pol;
  assign fire = ~cfg_q.mask & ~pend_q & ~rirr_q & (cfg_q.trig ? act : (act & ~act_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      rirr_q <= 1'b0;
    end else begin
      act_q <= act;
      if (clr_i)     pend_q <= 1'b0;
      else if (fire) pend_q <= 1'b1;
      // acceptance of a fixed level request takes priority over retirement
      if (clr_i && cfg_q.trig && cfg_q.mode == DM_FIXED) rirr_q <= 1'b1;
      else if (eoi_i && eoi_vec_i == cfg_q.vec)         rirr_q <= 1'b0;
    end
  end

  always_comb begin
    word_o           = '0;
    word_o[VEC_W-1:0] = cfg_q.vec;
    word_o[10:8]     = cfg_q.mode;
    word_o[B_STATUS] = pend_q;
    word_o[B_POL]    = cfg_q.pol;
    word_o[B_RIRR]   = rirr_q;
    word_o[B_TRIG]   = cfg_q.trig;
    word_o[B_MASK]   = cfg_q.mask;
  end

  assign cfg_o  = cfg_q;
  assign pend_o = pend_q;
  assign rirr_o = rirr_q;
  assign req_o  = pend_q & ~cfg_q.mask;
endmodule

// File: rtl/lvt_arb.sv
module lvt_arb #(
  parameter int N     = 6,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IDX_W'(i);
  end
  assign valid_o = |req_i;
endmodule

// File: rtl/lvt_ctrl.sv
module lvt_ctrl
  import lvt_pkg::*;
#(
  parameter int NUM_SRC    = 6,
  parameter int ADDR_W     = 7,
  parameter int STRIDE_LSB = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               reg_we_i,
  input  logic [3:0]         reg_be_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  input  logic               eoi_i,
  input  logic [VEC_W-1:0]   eoi_vec_i,
  output logic               req_valid_o,
  output logic [VEC_W-1:0]   req_vec_o,
  output logic [MODE_W-1:0]  req_mode_o,
  input  logic               req_ack_i
);
  localparam int IDX_W = $clog2(NUM_SRC);
  localparam int SEL_W = ADDR_W - STRIDE_LSB;
  localparam logic [SEL_W-1:0] NUM_L = SEL_W'(NUM_SRC);

  logic [SEL_W-1:0]   sel;
  logic               hit;
  logic [IDX_W-1:0]   gnt_idx;
  logic [NUM_SRC-1:0] pend_q, rirr_q, mask_q, req_w;
  cfg_t               cfg_w  [NUM_SRC];
  logic [WORD_W-1:0]  word_w [NUM_SRC];

  assign sel = reg_addr_i[ADDR_W-1:STRIDE_LSB];
  assign hit = (reg_addr_i[STRIDE_LSB-1:0] == '0) && (sel < NUM_L);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    lvt_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[g]),
      .wr_i      (reg_we_i && hit && sel == SEL_W'(g)),
      .be_i      (reg_be_i),
      .wdata_i   (reg_wdata_i),
      .eoi_i     (eoi_i),
      .eoi_vec_i (eoi_vec_i),
      .clr_i     (req_ack_i && req_valid_o && gnt_idx == IDX_W'(g)),
      .cfg_o     (cfg_w[g]),
      .pend_o    (pend_q[g]),
      .rirr_o    (rirr_q[g]),
      .req_o     (req_w[g]),
      .word_o    (word_w[g])
    );
    assign mask_q[g] = cfg_w[g].mask;
  end

  lvt_arb #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .req_i   (req_w),
    .valid_o (req_valid_o),
    .idx_o   (gnt_idx)
  );

  assign req_vec_o   = cfg_w[gnt_idx].vec;
  assign req_mode_o  = cfg_w[gnt_idx].mode;
  assign reg_rdata_o = hit ? word_w[sel[IDX_W-1:0]] : '0;
endmodule

// File: rtl/lvt_ctrl_chk.sv
module lvt_ctrl_chk #(
  parameter int NUM_SRC = 6,
  parameter int IDX_W   = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_o,
  input logic               req_ack_i,
  input logic [IDX_W-1:0]   gnt_idx,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] rirr_q
);
  logic [NUM_SRC-1:0] below, keep, idle_rirr;

  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      below[k] = IDX_W'(k) < gnt_idx;
      keep[k]  = pend_q[k] && !(req_valid_o && req_ack_i && gnt_idx == IDX_W'(k));
    end
  end
  assign idle_rirr = rirr_q & ~pend_q;

  a_r8_no_masked_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> !mask_q[gnt_idx]);

  a_r9_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (pend_q & ~mask_q & below) == '0);

  a_r7_status_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep != '0) |=> (pend_q & $past(keep)) == $past(keep));

  a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ack_i) |=> !pend_q[$past(gnt_idx)]);

  a_r6_rirr_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_rirr != '0) |=> (pend_q & $past(idle_rirr)) == '0);
endmodule

bind lvt_ctrl lvt_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_o (req_valid_o),
  .req_ack_i   (req_ack_i),
  .gnt_idx     (gnt_idx),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .rirr_q      (rirr_q)
);

// File: tb/sim_lvt_ctrl.sv
module sim_lvt_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic [5:0]  src_i = '0;
  logic        reg_we_i = 0;
  logic [3:0]  reg_be_i = '0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        eoi_i = 0;
  logic [7:0]  eoi_vec_i = '0, req_vec_o;
  logic        req_valid_o, req_ack_i = 0;
  logic [2:0]  req_mode_o;

  int total = 0, bad = 0;
  bit done = 0;

  // {pulse pattern, lowest index}
  localparam logic [8:0] TBL [6] = '{
    {6'b000001, 3'd0}, {6'b100000, 3'd5}, {6'b101010, 3'd1},
    {6'b111111, 3'd0}, {6'b010100, 3'd2}, {6'b011000, 3'd3}
  };

  lvt_ctrl u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic tick; @(posedge clk_i); #1; endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    tick();
    reg_we_i = 0; reg_be_i = '0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    reg_addr_i = a; #1;
    chk(reg_rdata_o == exp, tag, reg_rdata_o, exp);
  endtask

  task automatic req_chk(input logic v, input logic [7:0] vec, input string tag);
    chk(req_valid_o == v && (!v || req_vec_o == vec), tag, {23'b0, req_valid_o, req_vec_o}, {23'b0, v, v ? vec : req_vec_o});
  endtask

  task automatic ack;
    req_ack_i = 1; tick(); req_ack_i = 0;
  endtask

  function automatic logic [2:0] exp_mode(input int k);
    return k == 3 ? 3'b111 : k == 4 ? 3'b100 : k == 2 ? 3'b010 : 3'b000;
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1;
    tick();

    // R1 reset state, R2 layout
    for (int i = 0; i < 6; i++) rd_chk(7'(i * 16), 32'h0001_0000, "R1 reset word");
    req_chk(0, 0, "R1 no request after reset");

    // R2 decode of bad addresses
    wr(7'h04, 32'h0, 4'hF);
    wr(7'h60, 32'h0, 4'hF);
    rd_chk(7'h00, 32'h0001_0000, "R2 misaligned write ignored");
    rd_chk(7'h04, 32'h0, "R2 misaligned read zero");
    rd_chk(7'h60, 32'h0, "R2 index 6 read zero");

    // R3 byte strobes, read-only bits
    wr(7'h10, 32'hFFFF_FFFF, 4'b0001);
    rd_chk(7'h10, 32'h0001_00FF, "R3 vector only");
    wr(7'h10, 32'hFFFF_FFFF, 4'b0010);
    rd_chk(7'h10, 32'h0001_A7FF, "R3 mode pol trig, status and rirr ignore writes");

    // setup: edge, active high, masked, then unmask
    for (int i = 0; i < 6; i++)
      wr(7'(i * 16), 32'h0001_0000 | (32'(exp_mode(i)) << 8) | 32'(8'h30 + i), 4'b0111);
    for (int i = 0; i < 6; i++) wr(7'(i * 16), 32'h0, 4'b0100);
    rd_chk(7'h30, 32'h0000_0733, "R2 fields of entry 3");

    // R9 priority table
    for (int r = 0; r < 6; r++) begin
      logic [5:0] pat;
      pat = TBL[r][8:3];
      src_i = pat; tick(); src_i = '0;
      req_chk(1, 8'h30 + 8'(TBL[r][2:0]), "R9 lowest index first");
      for (int k = 0; k < 6; k++) if (pat[k]) begin
        req_chk(1, 8'(8'h30 + k), "R9 order of service");
        chk(req_mode_o == exp_mode(k), "R9 mode", 32'(req_mode_o), 32'(exp_mode(k)));
        ack();
      end
      req_chk(0, 0, "R5 one request per edge");
    end

    // R10, R5, R7 on entry 2
    src_i[2] = 1; #1;
    req_chk(0, 0, "R10 not before edge");
    tick();
    req_chk(1, 8'h32, "R10 visible after edge");
    rd_chk(7'h20, 32'h0000_1232, "R7 status set");
    src_i[2] = 0; tick();
    req_chk(1, 8'h32, "R5 held after input inactive");
    src_i[2] = 1; tick(); src_i[2] = 0; tick();
    ack();
    req_chk(0, 0, "R5 edge while pending adds nothing");
    rd_chk(7'h20, 32'h0000_0232, "R7 status clear after ack");

    // R8 mask on entry 0
    wr(7'h00, 32'h0001_0000, 4'b0100);
    src_i[0] = 1; tick(); src_i[0] = 0; tick();
    req_chk(0, 0, "R8 masked edge not presented");
    wr(7'h00, 32'h0, 4'b0100); tick();
    req_chk(0, 0, "R8 masked edge not latched");
    src_i[0] = 1; tick(); src_i[0] = 0;
    req_chk(1, 8'h30, "R8 unmasked edge");
    wr(7'h00, 32'h0001_0000, 4'b0100);
    req_chk(0, 0, "R8 pending hidden by mask");
    rd_chk(7'h00, 32'h0001_1030, "R8 status kept while masked");
    wr(7'h00, 32'h0, 4'b0100);
    req_chk(1, 8'h30, "R8 presented after unmask");
    ack();

    // R4 active-low on entry 5
    wr(7'h50, 32'h0001_2000, 4'b0110);
    wr(7'h50, 32'h0, 4'b0100); tick();
    req_chk(0, 0, "R4 steady low input no edge");
    src_i[5] = 1; tick();
    req_chk(0, 0, "R4 high input inactive");
    src_i[5] = 0; tick();
    req_chk(1, 8'h35, "R4 falling input is edge");
    ack();

    // R6 level on entry 1
    wr(7'h10, 32'h0001_8000, 4'b0110);
    wr(7'h10, 32'h0, 4'b0100);
    src_i[1] = 1; tick();
    req_chk(1, 8'h31, "R6 level request");
    rd_chk(7'h10, 32'h0000_9031, "R6 status before ack");
    ack();
    rd_chk(7'h10, 32'h0000_C031, "R6 rirr set on ack");
    repeat (3) tick();
    req_chk(0, 0, "R6 blocked by rirr");
    eoi_i = 1; eoi_vec_i = 8'h40; tick(); eoi_i = 0;
    rd_chk(7'h10, 32'h0000_C031, "R6 other vector keeps rirr");
    eoi_i = 1; eoi_vec_i = 8'h31; tick(); eoi_i = 0;
    rd_chk(7'h10, 32'h0000_8031, "R6 matching eoi clears rirr");
    tick();
    req_chk(1, 8'h31, "R6 re-request after eoi");
    ack();
    src_i[1] = 0;
    eoi_i = 1; eoi_vec_i = 8'h31; tick(); eoi_i = 0;
    tick(); tick();
    req_chk(0, 0, "R6 inactive level raises nothing");
    rd_chk(7'h10, 32'h0000_8031, "R6 final word");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule